// File: doc/BRIEF.md
# Configuration Unlock and High-Memory ROM Window Decoder

This block sits on a simple synchronous 8-bit I/O bus with a 16-bit address. It guards one control register behind a key sequence. It also decodes a firmware ROM window at the top of a 32-bit memory space. Software opens access by writing the unlock key to the active index port twice. It then selects a register by writing its index to the index port, and reads or writes that register through the data port. Writing the relock key to the index port closes access again.

The control register (index 03h) has three jobs. It picks which of two index/data port pairs is live, and its power-on value for that choice comes from a strap. It sets the size of the ROM window, between 1 MB and 8 MB below the 4 GB ceiling. It enables the chip-select and allows writes into the window. The decoder is combinational. It asserts the ROM chip-select on an enabled window hit. It asserts the write-permit output only for write hits when writes are allowed.

Top module: `cfg_rom_gate`

## Requirements
- R1: After reset, register 03h reads {000b, strap, 11b, 0b, 0b}: 0Ch with the strap low and 1Ch with it high. Decoding and write permission are off.
- R2: Two writes of 26h to the active index port, with no other I/O write between them, open configuration access. Idle cycles and reads between the two writes do not break the sequence.
- R3: Any other I/O write between the two key writes restarts detection. This covers a write to another address, or another value to the index port.
- R4: While locked, the data port reads FFh. Data port writes have no effect on register 03h or on the decoder.
- R5: Writing AAh to the index port while access is open returns the block to the locked state.
- R6: Bit 4 of register 03h selects the live port pair: 0 selects index 4Eh with data 4Fh, and 1 selects index 2Eh with data 2Fh. The port pair that is not selected is ignored.
- R7: Bits 7-5 of register 03h always read 0, and writes to them are ignored. A data port read at any index other than 03h returns FFh. With access open, an index port read returns the current index.
- R8: Bits 3-2 of register 03h set the window size: 00 = 1 MB, 01 = 2 MB, 10 = 4 MB, 11 = 8 MB. A memory address hits when all of its bits from bit 31 down to bit log2(size) are ones.
- R9: rom_cs_o is high only when a memory cycle is present, the address hits the window, and bit 1 of register 03h is set.
- R10: rom_wr_ok_o is high only for a write cycle that raises rom_cs_o while bit 0 of register 03h is set.
- R11: Read data appears on io_rdata_o in the cycle after the read strobe. In every other cycle io_rdata_o is FFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| strap_alt_i | input | 1 | Power-on choice of the port pair, sampled while in reset (1 = 2Eh/2Fh) |
| io_addr_i | input | 16 | I/O address |
| io_wdata_i | input | 8 | I/O write data |
| io_wr_i | input | 1 | Single-cycle I/O write strobe |
| io_rd_i | input | 1 | Single-cycle I/O read strobe |
| io_rdata_o | output | 8 | Registered read data, FFh when idle |
| mem_addr_i | input | 32 | Memory cycle address |
| mem_cyc_i | input | 1 | Memory cycle present |
| mem_we_i | input | 1 | Memory cycle is a write |
| rom_cs_o | output | 1 | ROM chip-select |
| rom_wr_ok_o | output | 1 | Write into the ROM window permitted |

## Verification
The hardest state to reach is the boundary of each window size. Register 03h must be rewritten through the full unlock, index and data sequence before every address probe. To do this, the bench unlocks once and then walks a vector table. Each row writes a new register value and probes addresses on both sides of the window edge.

The other hard state is a switch of the port pair while access is open. The bench flips bit 4 through the old data port. It then shows that only the new pair responds. It also resets with the strap high and shows that the key is ignored at the primary index port.

// File: rtl/cfg_rom_pkg.sv
package cfg_rom_pkg;
  typedef enum logic [1:0] {
    KEY_LOCKED = 2'd0,
    KEY_HALF   = 2'd1,
    KEY_OPEN   = 2'd2
  } key_state_e;

  localparam logic [7:0] KEY_UNLOCK = 8'h26;
  localparam logic [7:0] KEY_RELOCK = 8'hAA;
  localparam logic [7:0] IDX_ROMCTL = 8'h03;
  localparam logic [7:0] RD_IDLE    = 8'hFF;

  typedef struct packed {
    logic [2:0] rsvd;
    logic       alt_pair;
    logic [1:0] win_sz;
    logic       dec_en;
    logic       wr_en;
  } romctl_t;
endpackage

// File: rtl/cfg_key_fsm.sv
module cfg_key_fsm
  import cfg_rom_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic       idx_hit_i,
  input  logic [7:0] wdata_i,
  output logic       open_o
);
  key_state_e st_q, st_d;
  logic key_wr, relock_wr;

  assign key_wr    = idx_hit_i && (wdata_i == KEY_UNLOCK);
  assign relock_wr = idx_hit_i && (wdata_i == KEY_RELOCK);

  always_comb begin
    st_d = st_q;
    if (wr_i) begin
      unique case (st_q)
        KEY_LOCKED: st_d = key_wr ? KEY_HALF : KEY_LOCKED;
        KEY_HALF:   st_d = key_wr ? KEY_OPEN : KEY_LOCKED;  // any other write restarts
        KEY_OPEN:   st_d = relock_wr ? KEY_LOCKED : KEY_OPEN;
        default:    st_d = KEY_LOCKED;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= KEY_LOCKED;
    else         st_q <= st_d;
  end

  assign open_o = (st_q == KEY_OPEN);
endmodule

// File: rtl/cfg_regs.sv
module cfg_regs
  import cfg_rom_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       strap_alt_i,
  input  logic       open_i,
  input  logic       wr_i,
  input  logic       rd_i,
  input  logic       idx_hit_i,
  input  logic       dat_hit_i,
  input  logic [7:0] wdata_i,
  output logic       alt_pair_o,
  output logic [1:0] win_sz_o,
  output logic       dec_en_o,
  output logic       wr_en_o,
  output logic [7:0] rdata_o
);
  romctl_t    ctl_q;
  logic [7:0] index_q;
  logic       ctl_sel;

  assign ctl_sel = (index_q == IDX_ROMCTL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      index_q <= '0;
    end else if (wr_i && open_i && idx_hit_i && (wdata_i != KEY_RELOCK)) begin
      index_q <= wdata_i;
    end
  end

  // strap is sampled while reset is held
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q <= '{rsvd: 3'b000, alt_pair: strap_alt_i, win_sz: 2'b11, dec_en: 1'b0, wr_en: 1'b0};
    end else if (wr_i && open_i && dat_hit_i && ctl_sel) begin
      ctl_q <= '{rsvd: 3'b000, alt_pair: wdata_i[4], win_sz: wdata_i[3:2],
                 dec_en: wdata_i[1], wr_en: wdata_i[0]};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          rdata_o <= RD_IDLE;
    else if (rd_i && open_i && dat_hit_i) rdata_o <= ctl_sel ? ctl_q : RD_IDLE;
    else if (rd_i && open_i && idx_hit_i) rdata_o <= index_q;
    else                                  rdata_o <= RD_IDLE;
  end

  assign alt_pair_o = ctl_q.alt_pair;
  assign win_sz_o   = ctl_q.win_sz;
  assign dec_en_o   = ctl_q.dec_en;
  assign wr_en_o    = ctl_q.wr_en;
endmodule

// File: rtl/rom_window_dec.sv
module rom_window_dec #(
  parameter int ADDR_W   = 32,
  parameter int MIN_LOG2 = 20,
  parameter int SZ_W     = 2
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              cyc_i,
  input  logic              we_i,
  input  logic [SZ_W-1:0]   win_sz_i,
  input  logic              dec_en_i,
  input  logic              wr_en_i,
  output logic              cs_o,
  output logic              wr_ok_o
);
  localparam int NUM_SZ = 2 ** SZ_W;

  logic [NUM_SZ-1:0] hit_v;

  for (genvar g = 0; g < NUM_SZ; g++) begin : g_win
    localparam logic [ADDR_W-1:0] LOW_MASK =
      {{(ADDR_W-MIN_LOG2-g){1'b0}}, {(MIN_LOG2+g){1'b1}}};
    assign hit_v[g] = &(addr_i | LOW_MASK);
  end

  assign cs_o    = cyc_i && dec_en_i && hit_v[win_sz_i];
  assign wr_ok_o = cs_o && we_i && wr_en_i;
endmodule

// File: rtl/cfg_rom_gate.sv
module cfg_rom_gate
  import cfg_rom_pkg::*;
#(
  parameter int          IO_AW    = 16,
  parameter int          ADDR_W   = 32,
  parameter int          MIN_LOG2 = 20,
  parameter int          SZ_W     = 2,
  parameter logic [15:0] PRI_IDX  = 16'h004E,
  parameter logic [15:0] ALT_IDX  = 16'h002E
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              strap_alt_i,
  input  logic [IO_AW-1:0]  io_addr_i,
  input  logic [7:0]        io_wdata_i,
  input  logic              io_wr_i,
  input  logic              io_rd_i,
  output logic [7:0]        io_rdata_o,
  input  logic [ADDR_W-1:0] mem_addr_i,
  input  logic              mem_cyc_i,
  input  logic              mem_we_i,
  output logic              rom_cs_o,
  output logic              rom_wr_ok_o
);
  logic             alt_pair, dec_en, wr_en, open, idx_hit, dat_hit;
  logic [1:0]       win_sz;
  logic [IO_AW-1:0] idx_port;

  assign idx_port = alt_pair ? IO_AW'(ALT_IDX) : IO_AW'(PRI_IDX);
  assign idx_hit  = (io_addr_i == idx_port);
  assign dat_hit  = (io_addr_i == idx_port + IO_AW'(1));

  cfg_key_fsm i_key (
    .clk_i, .rst_ni,
    .wr_i      (io_wr_i),
    .idx_hit_i (idx_hit),
    .wdata_i   (io_wdata_i),
    .open_o    (open)
  );

  cfg_regs i_regs (
    .clk_i, .rst_ni,
    .strap_alt_i,
    .open_i     (open),
    .wr_i       (io_wr_i),
    .rd_i       (io_rd_i),
    .idx_hit_i  (idx_hit),
    .dat_hit_i  (dat_hit),
    .wdata_i    (io_wdata_i),
    .alt_pair_o (alt_pair),
    .win_sz_o   (win_sz),
    .dec_en_o   (dec_en),
    .wr_en_o    (wr_en),
    .rdata_o    (io_rdata_o)
  );

  rom_window_dec #(.ADDR_W(ADDR_W), .MIN_LOG2(MIN_LOG2), .SZ_W(SZ_W)) i_dec (
    .addr_i   (mem_addr_i),
    .cyc_i    (mem_cyc_i),
    .we_i     (mem_we_i),
    .win_sz_i (win_sz),
    .dec_en_i (dec_en),
    .wr_en_i  (wr_en),
    .cs_o     (rom_cs_o),
    .wr_ok_o  (rom_wr_ok_o)
  );
endmodule

// File: rtl/cfg_rom_gate_chk.sv
module cfg_rom_gate_chk #(
  parameter int ADDR_W   = 32,
  parameter int MIN_LOG2 = 20,
  parameter int SZ_W     = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              io_rd_i,
  input logic [7:0]        io_rdata_o,
  input logic [ADDR_W-1:0] mem_addr_i,
  input logic              mem_cyc_i,
  input logic              mem_we_i,
  input logic              rom_cs_o,
  input logic              rom_wr_ok_o
);
  localparam int TOP_LSB = MIN_LOG2 + (2 ** SZ_W) - 1;

  // R9
  cs_needs_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rom_cs_o |-> mem_cyc_i);

  // R10
  wr_ok_needs_write_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rom_wr_ok_o |-> (rom_cs_o && mem_we_i));

  // R8
  cs_in_top_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rom_cs_o |-> (&mem_addr_i[ADDR_W-1:TOP_LSB]));

  // R11
  rdata_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(io_rd_i) |-> (io_rdata_o == 8'hFF));
endmodule

bind cfg_rom_gate cfg_rom_gate_chk #(.ADDR_W(ADDR_W), .MIN_LOG2(MIN_LOG2), .SZ_W(SZ_W)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .io_rd_i     (io_rd_i),
  .io_rdata_o  (io_rdata_o),
  .mem_addr_i  (mem_addr_i),
  .mem_cyc_i   (mem_cyc_i),
  .mem_we_i    (mem_we_i),
  .rom_cs_o    (rom_cs_o),
  .rom_wr_ok_o (rom_wr_ok_o)
);

// File: tb/test_cfg_rom_gate.sv
module test_cfg_rom_gate;
  localparam int CLK_P = 10;

  typedef struct packed {
    logic [7:0]  cfg;
    logic [31:0] addr;
    logic        we;
    logic        cs;
    logic        wok;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{8'h0E, 32'hFF80_0000, 1'b0, 1'b1, 1'b0},
    '{8'h0E, 32'hFF7F_FFFF, 1'b0, 1'b0, 1'b0},
    '{8'h0E, 32'hFFFF_FFFF, 1'b1, 1'b1, 1'b0},
    '{8'h0F, 32'hFF80_0000, 1'b1, 1'b1, 1'b1},
    '{8'h03, 32'hFFF0_0000, 1'b1, 1'b1, 1'b1},
    '{8'h03, 32'hFFEF_FFFF, 1'b1, 1'b0, 1'b0},
    '{8'h07, 32'hFFE0_0000, 1'b0, 1'b1, 1'b0},
    '{8'h07, 32'hFFDF_FFFF, 1'b0, 1'b0, 1'b0},
    '{8'h0B, 32'hFFC0_0000, 1'b1, 1'b1, 1'b1},
    '{8'h0B, 32'hFFBF_FFFF, 1'b0, 1'b0, 1'b0},
    '{8'h0D, 32'hFFFF_FFFF, 1'b1, 1'b0, 1'b0},
    '{8'h0A, 32'h7FFF_FFFF, 1'b0, 1'b0, 1'b0}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        strap_alt_i = 1'b0;
  logic [15:0] io_addr_i = '0;
  logic [7:0]  io_wdata_i = '0;
  logic        io_wr_i = 1'b0;
  logic        io_rd_i = 1'b0;
  logic [7:0]  io_rdata_o;
  logic [31:0] mem_addr_i = '0;
  logic        mem_cyc_i = 1'b0;
  logic        mem_we_i = 1'b0;
  logic        rom_cs_o;
  logic        rom_wr_ok_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #(CLK_P/2) clk_i = ~clk_i;

  cfg_rom_gate i_cfg_rom_gate (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset(logic strap);
    @(negedge clk_i);
    rst_ni = 1'b0;
    strap_alt_i = strap;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic io_write(logic [15:0] a, logic [7:0] d);
    @(negedge clk_i);
    io_addr_i = a; io_wdata_i = d; io_wr_i = 1'b1;
    @(negedge clk_i);
    io_wr_i = 1'b0;
  endtask

  task automatic io_read(logic [15:0] a, output logic [7:0] d);
    @(negedge clk_i);
    io_addr_i = a; io_rd_i = 1'b1;
    @(negedge clk_i);
    io_rd_i = 1'b0;
    d = io_rdata_o;
  endtask

  task automatic unlock(logic [15:0] idx);
    io_write(idx, 8'h26);
    io_write(idx, 8'h26);
  endtask

  task automatic mem_probe(logic [31:0] a, logic we);
    mem_addr_i = a; mem_we_i = we; mem_cyc_i = 1'b1;
    #1;
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    do_reset(1'b0);

    // R4 / R11: locked data port and idle bus read FFh
    io_read(16'h004F, rd);
    chk("R4 locked data read", rd, 8'hFF);
    @(negedge clk_i);
    chk("R11 idle after read", io_rdata_o, 8'hFF);

    // R3: intervening write to another port breaks the key
    io_write(16'h004E, 8'h26);
    io_write(16'h0080, 8'h26);
    io_write(16'h004E, 8'h26);
    io_write(16'h004E, 8'h03);
    io_read(16'h004F, rd);
    chk("R3 key restarted", rd, 8'hFF);

    // R2 / R1: proper unlock, defaults with strap low; idle reads between keys allowed
    io_write(16'h004E, 8'h26);
    io_read(16'h0060, rd);
    io_write(16'h004E, 8'h26);
    io_write(16'h004E, 8'h03);
    io_read(16'h004F, rd);
    chk("R1 R2 default after unlock", rd, 8'h0C);
    io_read(16'h004E, rd);
    chk("R7 index readback", rd, 8'h03);
    mem_probe(32'hFFFF_FFFF, 1'b1);
    chk("R1 decoder off after reset", {rom_cs_o, rom_wr_ok_o}, 2'b00);
    mem_cyc_i = 1'b0;

    // R7: reserved bits and unimplemented index
    io_write(16'h004F, 8'hEC);
    io_read(16'h004F, rd);
    chk("R7 reserved bits read zero", rd, 8'h0C);
    io_write(16'h004E, 8'h05);
    io_read(16'h004F, rd);
    chk("R7 other index reads FFh", rd, 8'hFF);

    // R5 / R4: relock, then a data write is ignored
    io_write(16'h004E, 8'hAA);
    io_read(16'h004F, rd);
    chk("R5 relocked data read", rd, 8'hFF);
    io_write(16'h004F, 8'h0F);
    mem_probe(32'hFFFF_FFFF, 1'b1);
    chk("R4 locked write no decode", {rom_cs_o, rom_wr_ok_o}, 2'b00);
    mem_cyc_i = 1'b0;
    unlock(16'h004E);
    io_write(16'h004E, 8'h03);
    io_read(16'h004F, rd);
    chk("R4 register unchanged", rd, 8'h0C);

    // R8 R9 R10: window vectors
    for (int i = 0; i < NV; i++) begin
      io_write(16'h004F, VECS[i].cfg);
      mem_probe(VECS[i].addr, VECS[i].we);
      chk("R8 R9 cs vector", rom_cs_o, VECS[i].cs);
      chk("R10 write permit vector", rom_wr_ok_o, VECS[i].wok);
      mem_cyc_i = 1'b0;
      #1;
      chk("R9 no cycle no cs", rom_cs_o, 1'b0);
    end

    // R6: switch pair via bit 4
    io_write(16'h004F, 8'h1C);
    io_read(16'h004F, rd);
    chk("R6 old pair ignored", rd, 8'hFF);
    io_write(16'h002E, 8'h03);
    io_read(16'h002F, rd);
    chk("R6 new pair live", rd, 8'h1C);

    // R1 / R6: strap high selects alternate pair at reset
    do_reset(1'b1);
    unlock(16'h004E);
    io_write(16'h004E, 8'h03);
    io_read(16'h004F, rd);
    chk("R6 primary key ignored", rd, 8'hFF);
    unlock(16'h002E);
    io_write(16'h002E, 8'h03);
    io_read(16'h002F, rd);
    chk("R1 strap default", rd, 8'h1C);
    @(negedge clk_i);
    chk("R11 idle after read", io_rdata_o, 8'hFF);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule